// File: doc/BRIEF.md
# Serial Register Access Front End

This block is the slave side of a four-wire serial link that gives a host single-register access to an 8-bit register space. Each exchange is one fixed 16-bit frame, sent most significant bit first. The top bit of the frame gives the direction. The next seven bits give the register address. The low byte carries the value to store on a write and is zero on a read. On a read, the addressed value comes back on the serial output during the second byte of the same frame.

The serial clock, chip select and data input are treated as asynchronous pins. They pass through synchronisers into a faster system clock, and the serial clock edges are detected in that domain. The slave samples its data input on rising serial clock edges and changes its data output on falling edges (clock idle low). Toward the register file it drives a plain parallel bus: an address, write data, a one-cycle write strobe and a one-cycle read strobe. It takes read data back combinationally in the cycle of the read strobe. The register file sits outside this block, and so do any side effects a read or write has inside it.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 16 bits, most significant bit first. Bit 15 = 1 selects a write and 0 selects a read. Bits 14..8 are the register address and bits 7..0 are the write value.
- R2: A write frame raises `bus_we_o` for exactly one system cycle after its 16th rising serial clock edge. While it is high, `bus_addr_o` holds bits 14..8 and `bus_wdata_o` holds bits 7..0.
- R3: A read frame raises `bus_re_o` for exactly one system cycle after its 8th rising serial clock edge, with `bus_addr_o` holding bits 14..8. The address stays stable in the following cycle. A read frame never raises `bus_we_o`.
- R4: During bits 7..0 of a read frame, the serial output carries the value on `bus_rdata_i` captured with the read strobe, MSB first. Each bit is set up before the rising edge that samples it.
- R5: If chip select goes high before 16 bits have arrived, the write is dropped. The bit counter returns to zero, so the next frame is decoded from its first bit.
- R6: A read frame cut short before its 8th bit raises no read strobe.
- R7: Rising edges beyond the 16th within one chip select window are ignored, and a frame produces at most one strobe.
- R8: Out of reset, both strobes are low and the serial output is 0.
- R9: The serial output is 0 during the first byte of every frame, during the whole of a write frame, and while chip select is high.
- R10: The write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock pin, idle low |
| cs_ni | input | 1 | Chip select pin, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| bus_addr_o | output | ADDR_W (7) | Register address |
| bus_wdata_o | output | DATA_W (8) | Write value |
| bus_we_o | output | 1 | One-cycle write strobe |
| bus_re_o | output | 1 | One-cycle read strobe |
| bus_rdata_i | input | DATA_W (8) | Read value, sampled in the read strobe cycle |

## Verification
The bench aims at frames cut short by chip select. A design that strobes on a partial frame corrupts a register. A design that keeps its bit count across the gap decodes the next frame from the middle, and the read-back that follows exposes this. Frames carrying 20 clocks instead of 16 catch a counter that wraps and writes twice. Reads that follow writes to address 0, to the top address and to random addresses check the byte alignment of the returned data: a load one falling edge late shifts the byte by one bit. The first byte and all of a write frame are checked to be zero on the output.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRM_ADDR_W = 7;
  localparam int FRM_DATA_W = 8;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_reg_frame.sv
module spi_reg_frame import spi_reg_pkg::*; #(
  parameter int ADDR_W = FRM_ADDR_W,
  parameter int DATA_W = FRM_DATA_W,
  localparam int FRAME_W = 1 + ADDR_W + DATA_W,
  localparam int HDR_W   = 1 + ADDR_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o
);
  logic [FRAME_W-2:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               we_q, re_q;
  logic [FRAME_W-1:0] frame_w;
  logic               take;

  assign frame_w = {sh_q, mosi_i};
  // edges past the last frame bit are dropped
  assign take = cs_active_i && rise_i && (cnt_q < CNT_W'(FRAME_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (!cs_active_i) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (take) begin
        sh_q  <= frame_w[FRAME_W-2:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(HDR_W - 1)) begin
          addr_q <= frame_w[ADDR_W-1:0];
          re_q   <= (frame_w[ADDR_W] == DIR_READ);
        end
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          wdata_q <= frame_w[DATA_W-1:0];
          we_q    <= (frame_w[FRAME_W-1] == DIR_WRITE);
        end
      end
    end
  end

  assign bit_cnt_o = cnt_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign we_o      = we_q;
  assign re_o      = re_q;
endmodule

// File: rtl/spi_reg_miso.sv
module spi_reg_miso import spi_reg_pkg::*; #(
  parameter int ADDR_W = FRM_ADDR_W,
  parameter int DATA_W = FRM_DATA_W,
  localparam int FRAME_W = 1 + ADDR_W + DATA_W,
  localparam int HDR_W   = 1 + ADDR_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              miso_o
);
  logic [DATA_W-1:0] tx_q;
  logic              shift;

  // fall at count HDR_W already shows the MSB; later falls advance
  assign shift = fall_i && (bit_cnt_i > CNT_W'(HDR_W)) && (bit_cnt_i < CNT_W'(FRAME_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tx_q <= '0;
    else if (!cs_active_i)  tx_q <= '0;
    else if (load_i)        tx_q <= load_data_i;
    else if (shift)         tx_q <= {tx_q[DATA_W-2:0], 1'b0};
  end

  assign miso_o = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave import spi_reg_pkg::*; #(
  parameter int ADDR_W      = FRM_ADDR_W,
  parameter int DATA_W      = FRM_DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [2:0]       pins_s;
  logic             sclk_s, cs_n_s, mosi_s;
  logic             sclk_d_q;
  logic             sclk_rise, sclk_fall;
  logic [CNT_W-1:0] bit_cnt;

  // {sclk, cs_n, mosi}; chip select resets inactive
  spi_reg_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, mosi_i}),
    .q_o    (pins_s)
  );

  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sclk_fall = ~sclk_s & sclk_d_q;

  spi_reg_frame #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_active_i (~cs_n_s),
    .rise_i      (sclk_rise),
    .mosi_i      (mosi_s),
    .bit_cnt_o   (bit_cnt),
    .addr_o      (bus_addr_o),
    .wdata_o     (bus_wdata_o),
    .we_o        (bus_we_o),
    .re_o        (bus_re_o)
  );

  spi_reg_miso #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_miso (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_active_i (~cs_n_s),
    .fall_i      (sclk_fall),
    .bit_cnt_i   (bit_cnt),
    .load_i      (bus_re_o),
    .load_data_i (bus_rdata_i),
    .miso_o      (miso_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int ADDR_W  = 7,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_s_i,
  input logic [CNT_W-1:0]  bit_cnt_i,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              miso_i
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i)); // R10

  AST_WE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i); // R2

  AST_RE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> !re_i); // R3

  AST_RE_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> $stable(addr_i)); // R3

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(FRAME_W)); // R7

  AST_CS_CLEARS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> (bit_cnt_i == '0)); // R5

  AST_MISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !miso_i); // R9
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
  .ADDR_W  (ADDR_W),
  .FRAME_W (FRAME_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_n_s_i  (cs_n_s),
  .bit_cnt_i (bit_cnt),
  .we_i      (bus_we_o),
  .re_i      (bus_re_o),
  .addr_i    (bus_addr_o),
  .miso_i    (miso_o)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int AW         = 7;
  localparam int DW         = 8;
  localparam int NREG       = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic we, re;

  logic [DW-1:0] mem     [NREG];
  logic [DW-1:0] exp_mem [NREG];
  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0;
  logic [AW-1:0] last_waddr, last_raddr;
  logic [DW-1:0] last_wdata;

  spi_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_we_o(we),
    .bus_re_o(re), .bus_rdata_i(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rdata = mem[addr];

  // bus-side register file model and strobe monitor
  always @(negedge clk) begin
    if (rst_n && we) begin
      we_cnt++;
      last_waddr = addr;
      last_wdata = wdata;
      mem[addr]  = wdata;
    end
    if (rst_n && re) begin
      re_cnt++;
      last_raddr = addr;
    end
  end

  function automatic logic [15:0] mk_frame(logic wr, logic [AW-1:0] a, logic [DW-1:0] d);
    return {wr, a, wr ? d : 8'h00};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] fr, input int nbits, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? fr[15-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 16) rx[15-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, int nbits, string req);
    logic [15:0] rx;
    int w0 = we_cnt;
    int r0 = re_cnt;
    xfer(mk_frame(1'b1, a, d), nbits, rx);
    if (nbits >= 16) begin
      exp_mem[a] = d;
      check(we_cnt == w0 + 1, req, "write strobe count", we_cnt - w0, 1);
      check(last_waddr == a, req, "write address", last_waddr, a);
      check(last_wdata == d, req, "write data", last_wdata, d);
    end else begin
      check(we_cnt == w0, "R5", "write strobes on cut frame", we_cnt - w0, 0);
    end
    check(re_cnt == r0, "R3", "read strobes in write frame", re_cnt - r0, 0);
    check(rx == 16'h0000, "R9", "miso during write frame", rx, 0);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    logic [15:0] rx;
    int w0 = we_cnt;
    int r0 = re_cnt;
    xfer(mk_frame(1'b0, a, 8'h00), 16, rx);
    check(re_cnt == r0 + 1, "R3", "read strobe count", re_cnt - r0, 1);
    check(last_raddr == a, "R3", "read address", last_raddr, a);
    check(we_cnt == w0, "R3", "write strobes in read frame", we_cnt - w0, 0);
    check(rx[7:0] == exp_mem[a], req, "read data on miso", rx[7:0], exp_mem[a]);
    check(rx[15:8] == 8'h00, "R9", "miso first byte", rx[15:8], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    int r0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NREG; i++) begin
      mem[i]     = DW'(i * 7 + 3);
      exp_mem[i] = DW'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    check(miso == 1'b0, "R8", "miso in reset", miso, 0);
    check(we == 1'b0 && re == 1'b0, "R8", "strobes in reset", {we, re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(miso == 1'b0, "R8", "miso after reset", miso, 0);

    // R1 basic decode, address 0 and top address
    do_write(7'h05, 8'hA5, 16, "R2");
    do_read(7'h05, "R4");
    do_write(7'h00, 8'h3C, 16, "R1");
    do_read(7'h00, "R1");
    do_write(7'h7F, 8'h81, 16, "R1");
    do_read(7'h7F, "R4");

    // R5 cut write, then a clean read proves the counter restarted
    do_write(7'h0A, 8'hFF, 10, "R5");
    do_read(7'h0A, "R5");
    do_write(7'h0B, 8'h00, 15, "R5");
    do_read(7'h0B, "R5");

    // R6 cut read before header completes
    r0 = re_cnt;
    xfer(mk_frame(1'b0, 7'h12, 8'h00), 5, rx);
    check(re_cnt == r0, "R6", "read strobe on cut header", re_cnt - r0, 0);
    r0 = re_cnt;
    xfer(mk_frame(1'b0, 7'h12, 8'h00), 7, rx);
    check(re_cnt == r0, "R6", "read strobe after 7 bits", re_cnt - r0, 0);

    // R7 overlong frames
    do_write(7'h11, 8'h5A, 20, "R7");
    do_read(7'h11, "R7");
    r0 = re_cnt;
    xfer(mk_frame(1'b0, 7'h11, 8'h00), 24, rx);
    check(re_cnt == r0 + 1, "R7", "read strobes on long frame", re_cnt - r0, 1);
    check(rx[7:0] == exp_mem[7'h11], "R7", "long frame read data", rx[7:0], exp_mem[7'h11]);

    // random traffic over a small address window to force read-after-write hits
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 31));
      logic [DW-1:0] d = DW'($urandom);
      if ($urandom_range(0, 1) == 1) do_write(a, d, 16, "R2");
      else                           do_read(a, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule